// File: doc/BRIEF.md
# Auto-Reload Timer Square-Wave Generator

This block is a 16-bit timer that counts up, reloads itself from a software-written reload value each time it wraps past its terminal count, and flips a toggle flip-flop on every wrap. The result is a square wave with a 50% duty cycle on a clock-out pin. The counter advances once every two system clocks, so each half period lasts 2×(65536 − reload) clocks. The output frequency is therefore the system clock divided by 4×(65536 − reload). With a 16 MHz system clock this spans about 61 Hz (reload 0) up to 4 MHz (reload 0xFFFF).

The square wave reaches the pin only when the block is in timer mode (count select low) and the pin enable is set. Otherwise the pin carries a general-purpose output value supplied from outside. A run control starts and stops counting, and while stopped everything holds. Every wrap also raises a one-cycle rollover strobe that other logic, such as a baud-rate divider, may use. Both consumers are paced by the one reload value, so their rates are tied together. An interrupt pulse comes out on a wrap only when the square-wave output is disabled. Clock-out wraps never request an interrupt.

The reload value is written one byte at a time through separate high and low write strobes. A new value written while the timer runs does not disturb the count in progress. It is first used at the next wrap.

Top module: `clkout_timer`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the toggle flip-flop is 0, the reload value is 0, the counter sits at 0xFFFF, and ovf_strobe and irq_pulse are 0. With out_en low after reset, clk_out equals gpio_val.
- R2: While run_en is 1 and count_sel is 0, the counter advances once every 2 clocks. A tick at 0xFFFF loads the reload value instead of wrapping to 0. With reload 0xFFFF, a wrap therefore occurs every 2 clocks.
- R3: With out_en 1 and count_sel 0, clk_out shows the toggle flip-flop, which inverts on every wrap. Each high phase and each low phase lasts exactly 2×(65536 − reload) clocks (50% duty).
- R4: While run_en is 0, the counter, the prescaler phase and the toggle flip-flop hold. No wrap, no ovf_strobe and no clk_out change occur.
- R5: While count_sel is 1 (counter mode, whose external count input lies outside this block), the timer does not advance and clk_out equals gpio_val.
- R6: While out_en is 0 or count_sel is 1, clk_out equals gpio_val and the toggle flip-flop does not change.
- R7: ovf_strobe is high for exactly the one clock after each wrap, whatever out_en is. It is never high on two consecutive clocks.
- R8: irq_pulse is high in the clock after a wrap only if out_en was 0 at that wrap. A wrap that occurs while out_en is 1 never raises irq_pulse.
- R9: A clock with rld_wr_hi high writes rld_wdata into reload bits 15:8. A clock with rld_wr_lo high writes rld_wdata into bits 7:0. A value written while running is first loaded at the next wrap, so the half period already in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | 1 = timer runs, 0 = timer holds |
| count_sel | input | 1 | 0 = timer mode (prescaled clock), 1 = counter mode |
| out_en | input | 1 | 1 = square wave drives clk_out |
| gpio_val | input | 1 | General-purpose pin value used when the square wave is not selected |
| rld_wr_hi | input | 1 | Write strobe for reload bits 15:8 |
| rld_wr_lo | input | 1 | Write strobe for reload bits 7:0 |
| rld_wdata | input | 8 | Reload byte being written |
| clk_out | output | 1 | Clock-out pin value |
| ovf_strobe | output | 1 | One-clock pulse after each wrap |
| irq_pulse | output | 1 | One-clock interrupt request after a wrap made with out_en low |

## Verification
Each internal register of this block shows up at the ports within one wrap interval. A wrong toggle state is visible on clk_out at the very next clock. A counter or reload error shifts the next ovf_strobe and the next clk_out edge, at most 2×(65536 − reload) clocks later. A prescaler fault changes the spacing between consecutive strobes by a factor of two. For this reason the bench compares clk_out, ovf_strobe and irq_pulse against its model on every clock. It also measures edge spacing directly for several reload values, including a reload rewritten in the middle of a half period.

// File: rtl/clkout_pkg.sv
// Package: shared mode type and decode for the auto-reload clock-out timer.
// Assumes: count select high means the external count path, which lives outside.
package clkout_pkg;

    typedef enum logic [1:0] {
        TM_HALT   = 2'd0,
        TM_EXTCNT = 2'd1,
        TM_TIMER  = 2'd2
    } tmr_mode_e;

    // Decode the run and count-select controls into the timer's operating mode.
    function automatic tmr_mode_e decode_mode(input logic run, input logic csel);
        if (csel)
            return TM_EXTCNT;
        else if (run)
            return TM_TIMER;
        else
            return TM_HALT;
    endfunction

endpackage

// File: rtl/clkout_prescale.sv
// Module: clock-enable prescaler. Emits one tick every DIV enabled clocks.
// Assumes: the phase holds while adv is low, so a stop/start keeps the phase.
module clkout_prescale #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = adv;
        end else begin : g_div
            localparam int unsigned PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase_q;

            // Step the phase on each enabled clock and wrap at the last phase.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase_q <= '0;
                else if (adv)
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
            end

            assign tick = adv && (phase_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/clkout_counter.sv
// Module: up-counter with byte-written reload register.
// Assumes: counter resets to terminal count so the first tick loads the reload.
//          Reload writes land in the register only; the count uses them at wrap.
module clkout_counter #(
    parameter int unsigned W  = 16,
    parameter int unsigned BW = W / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [BW-1:0] wdata,
    output logic          wrap,
    output logic [W-1:0]  reload_q
);

    logic [W-1:0] cnt_q;
    logic         at_top;

    assign at_top = &cnt_q;
    assign wrap   = tick && at_top;

    // Capture reload bytes from their individual write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else begin
            if (wr_hi) reload_q[W-1:BW] <= wdata;
            if (wr_lo) reload_q[BW-1:0] <= wdata;
        end
    end

    // Count on each tick; load the reload value instead of wrapping to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (tick)
            cnt_q <= at_top ? reload_q : cnt_q + W'(1);
    end

endmodule

// File: rtl/clkout_toggle.sv
// Module: toggle flip-flop that forms the 50% duty square wave.
// Assumes: flip is a single-cycle pulse; holds value otherwise.
module clkout_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic q
);

    // Invert the stored level on each flip request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (flip)
            q <= ~q;
    end

endmodule

// File: rtl/clkout_timer.sv
// Module: auto-reload timer with square-wave clock-out and shared rollover strobe.
// Does:   prescales the clock, counts up, reloads on wrap, toggles the pin source,
//         and pulses a rollover strobe and (outside clock-out mode) an interrupt.
// Assumes: PRESC_DIV >= 2 so strobes are never back to back; reload is byte-written.
module clkout_timer #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PRESC_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               count_sel,
    input  logic               out_en,
    input  logic               gpio_val,
    input  logic               rld_wr_hi,
    input  logic               rld_wr_lo,
    input  logic [CNT_W/2-1:0] rld_wdata,
    output logic               clk_out,
    output logic               ovf_strobe,
    output logic               irq_pulse
);
    import clkout_pkg::*;

    localparam int unsigned BW = CNT_W / 2;

    tmr_mode_e        mode;
    logic             adv;
    logic             tick;
    logic             wrap;
    logic             tff_q;
    logic             wave_sel;
    logic [CNT_W-1:0] reload_q;

    assign mode     = decode_mode(run_en, count_sel);
    assign adv      = (mode == TM_TIMER);
    assign wave_sel = out_en && !count_sel;

    clkout_prescale #(.DIV(PRESC_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .tick (tick)
    );

    clkout_counter #(.W(CNT_W), .BW(BW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_hi   (rld_wr_hi),
        .wr_lo   (rld_wr_lo),
        .wdata   (rld_wdata),
        .wrap    (wrap),
        .reload_q(reload_q)
    );

    clkout_toggle u_tff (
        .clk  (clk),
        .rst_n(rst_n),
        .flip (wrap && out_en),
        .q    (tff_q)
    );

    // Register the rollover strobe and the interrupt request (suppressed in clock-out mode).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_strobe <= 1'b0;
            irq_pulse  <= 1'b0;
        end else begin
            ovf_strobe <= wrap;
            irq_pulse  <= wrap && !out_en;
        end
    end

    // Select the pin source: square wave in clock-out mode, else the GPIO value.
    always_comb begin
        clk_out = wave_sel ? tff_q : gpio_val;
    end

endmodule

// File: rtl/clkout_timer_chk.sv
// Module: assertion checker for clkout_timer, attached with bind below.
// Assumes: PRESC_DIV >= 2; live_q masks properties that look one cycle back.
module clkout_timer_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned BW    = CNT_W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             count_sel,
    input logic             out_en,
    input logic             rld_wr_hi,
    input logic             rld_wr_lo,
    input logic [BW-1:0]    rld_wdata,
    input logic             ovf_strobe,
    input logic             irq_pulse,
    input logic             tff,
    input logic [CNT_W-1:0] reload
);

    logic live_q;

    // Mark that at least one clock has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ovf_strobe); // R8
    AST_NO_IRQ_CLKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(out_en)) |-> !irq_pulse); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_strobe |=> !ovf_strobe); // R7
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en || count_sel) |=> !ovf_strobe); // R4
    AST_TFF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$stable(tff)) |-> (ovf_strobe && $past(out_en))); // R3
    AST_HOLD_TFF: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(run_en)) |-> $stable(tff)); // R4
    AST_RLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(rld_wr_hi)) |-> (reload[CNT_W-1:BW] == $past(rld_wdata))); // R9
    AST_RLD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(rld_wr_lo)) |-> (reload[BW-1:0] == $past(rld_wdata))); // R9

endmodule

bind clkout_timer clkout_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .count_sel (count_sel),
    .out_en    (out_en),
    .rld_wr_hi (rld_wr_hi),
    .rld_wr_lo (rld_wr_lo),
    .rld_wdata (rld_wdata),
    .ovf_strobe(ovf_strobe),
    .irq_pulse (irq_pulse),
    .tff       (tff_q),
    .reload    (reload_q)
);

// File: tb/tb_clkout_timer.sv
`timescale 1ns/1ps
module tb_clkout_timer;

    localparam real CYC = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0, count_sel = 1'b0, out_en = 1'b0, gpio_val = 1'b0;
    logic       rld_wr_hi = 1'b0, rld_wr_lo = 1'b0;
    logic [7:0] rld_wdata = 8'h00;
    logic       clk_out, ovf_strobe, irq_pulse;

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural reference state
    int m_ph = 0, m_cnt = 65535, m_rld = 0;
    bit m_tff = 0, m_ovf = 0, m_irq = 0;

    always #(CYC/2) clk = ~clk;

    clkout_timer dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .count_sel(count_sel),
        .out_en(out_en), .gpio_val(gpio_val), .rld_wr_hi(rld_wr_hi),
        .rld_wr_lo(rld_wr_lo), .rld_wdata(rld_wdata), .clk_out(clk_out),
        .ovf_strobe(ovf_strobe), .irq_pulse(irq_pulse)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model advanced at each edge, compared 1 ns later.
    always @(posedge clk) begin
        bit tk, wr;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 65535; m_rld = 0; m_tff = 0; m_ovf = 0; m_irq = 0;
        end else begin
            tk = 0;
            if (run_en && !count_sel) begin
                if (m_ph == 1) begin tk = 1; m_ph = 0; end else m_ph = 1;
            end
            wr = tk && (m_cnt == 65535);
            m_ovf = wr;
            m_irq = wr && !out_en;
            if (tk) m_cnt = wr ? m_rld : m_cnt + 1;
            if (wr && out_en) m_tff = !m_tff;
            if (rld_wr_hi) m_rld = (m_rld & 'h00FF) | (int'(rld_wdata) << 8);
            if (rld_wr_lo) m_rld = (m_rld & 'hFF00) | int'(rld_wdata);
        end
        #1;
        if (rst_n && !done) begin
            check("R3", "clk_out vs model", clk_out,
                  (out_en && !count_sel) ? m_tff : gpio_val);
            check("R7", "ovf_strobe vs model", ovf_strobe, m_ovf);
            check("R8", "irq_pulse vs model", irq_pulse, m_irq);
        end
    end

    // Count clocks until clk_out changes; returns at 1 ns after the changing edge.
    task automatic wait_edge(output int n);
        logic prev;
        prev = clk_out;
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (clk_out == prev);
    endtask

    task automatic wr_reload(input logic [15:0] v);
        @(negedge clk); rld_wr_hi = 1; rld_wdata = v[15:8];
        @(negedge clk); rld_wr_hi = 0; rld_wr_lo = 1; rld_wdata = v[7:0];
        @(negedge clk); rld_wr_lo = 0;
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            done = 1; tests++; fails++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n, no, ni, nc;
        logic v;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #2;
        check("R1", "clk_out after reset", clk_out, 0);
        check("R1", "ovf_strobe after reset", ovf_strobe, 0);
        check("R1", "irq_pulse after reset", irq_pulse, 0);

        @(negedge clk); gpio_val = 1;
        @(posedge clk); #2;
        check("R6", "clk_out follows gpio", clk_out, 1);
        @(negedge clk); gpio_val = 0;

        // R3: reload 0xFFF0 -> half period 32 clocks
        wr_reload(16'hFFF0);
        @(negedge clk); out_en = 1; run_en = 1;
        wait_edge(n);
        wait_edge(n); check("R3", "high/low phase 0xFFF0", n, 32);
        wait_edge(n); check("R3", "next phase 0xFFF0 (duty)", n, 32);

        // R7: ten wraps in 320 clocks after an edge, no irq in clock-out mode
        wait_edge(n);
        no = 0; ni = 0;
        for (int i = 0; i < 320; i++) begin
            @(posedge clk); #2;
            if (ovf_strobe) no++;
            if (irq_pulse) ni++;
        end
        check("R7", "strobes in window", no, 10);
        check("R8", "irq in clock-out mode", ni, 0);

        // R9: rewrite low byte mid-phase; current phase keeps old length
        wait_edge(n);
        @(negedge clk); rld_wr_lo = 1; rld_wdata = 8'hE0;
        @(negedge clk); rld_wr_lo = 0;
        wait_edge(n); check("R9", "phase in progress (one clock spent on write)", n, 31);
        wait_edge(n); check("R9", "phase after reload 0xFFE0", n, 64);

        // R4: stop holds everything
        @(negedge clk); run_en = 0; v = clk_out;
        no = 0; nc = 0;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk); #2;
            if (ovf_strobe) no++;
            if (clk_out != v) nc++;
        end
        check("R4", "strobes while stopped", no, 0);
        check("R4", "clk_out changes while stopped", nc, 0);
        @(negedge clk); run_en = 1;

        // R5: counter mode shows gpio and does not advance
        @(negedge clk); count_sel = 1; gpio_val = 1;
        no = 0; nc = 0;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk); #2;
            if (ovf_strobe) no++;
            if (clk_out != gpio_val) nc++;
        end
        check("R5", "strobes in counter mode", no, 0);
        check("R5", "clk_out != gpio in counter mode", nc, 0);
        @(negedge clk); count_sel = 0; gpio_val = 0;

        // R2: reload 0xFFFF -> wrap every 2 clocks
        wr_reload(16'hFFFF);
        wait_edge(n); wait_edge(n);
        wait_edge(n); check("R2", "phase with reload 0xFFFF", n, 2);
        wait_edge(n); check("R2", "next phase reload 0xFFFF", n, 2);

        // R8: output disabled -> irq follows each strobe, pin shows gpio
        wr_reload(16'hFFF0);
        @(negedge clk); out_en = 0; gpio_val = 1;
        no = 0; ni = 0; nc = 0;
        for (int i = 0; i < 320; i++) begin
            @(posedge clk); #2;
            if (ovf_strobe) no++;
            if (irq_pulse) ni++;
            if (clk_out != gpio_val) nc++;
        end
        check("R8", "irq count equals strobe count", ni, no);
        check("R8", "strobes present with output off", (no >= 9) ? 1 : 0, 1);
        check("R6", "clk_out != gpio with output off", nc, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule